// File: doc/BRIEF.md
# SDRAM Single-Write Command Sequencer

This block turns one host write request into the command sequence that stores a single 16-bit word in an SDRAM. The request gives a bank, a row, a column, the data word, two byte-mask bits, and a flag that chooses whether the closing precharge applies to one bank or to all banks. The block opens the row, writes the word in a burst of one with auto precharge disabled, and closes the row with an explicit precharge. Every cycle without one of these three commands carries a no-operation.

All intervals are set as nanosecond parameters together with the clock period. Each one becomes a cycle count at elaboration, rounded up. The fixed command slots come from these counts. The write is placed at the row-to-column delay. The precharge waits for the later of two limits: the minimum row-active time, and the write recovery counted from the data beat. The next activate waits for the later of two limits: precharge plus the precharge period, and the full row-cycle time. With the defaults (8 ns clock; 20/20/48/80/15 ns) the write lands 3 cycles after the activate, the precharge 6 cycles after it, and the earliest next activate 10 cycles after it.

Top module: `sdram_wr_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, the command pins carry NOP, clock enable is high, the data output enable is low, ready is high, done is low and both mask bits are high.
- R2: The command encoding is {chip select, row strobe, column strobe, write enable}, all active low: activate 0011, write 0100, precharge 0010, NOP 0111. A request accepted at a clock edge (valid and ready both high) puts activate on the pins in the next cycle, with the row on the address bus and the bank on the bank pins.
- R3: The write command appears exactly 3 cycles after the activate, which is ceil(20/8). It carries the column zero-extended on the address bus, so address bit 10 is low (no auto precharge), and the bank on the bank pins.
- R4: The data word and the request's mask bits are driven in the write cycle, and the data output enable is high in that cycle only. The data lines are zero and both mask bits are high in every other cycle.
- R5: The precharge command appears exactly 6 cycles after the activate. This is the later of the minimum row-active time (ceil(48/8) = 6) and the write slot plus write recovery (3 + ceil(15/8) = 5). Address bit 10 equals the request's all-banks flag, the other address bits are zero, and the bank pins carry the request's bank.
- R6: Done is high for exactly one cycle, the cycle of the precharge command.
- R7: Ready goes low in the cycle after an acceptance and returns high 9 cycles after the activate. A request that is waiting therefore gets its activate exactly 10 cycles after the previous one. This is the later of the row-cycle time (ceil(80/8) = 10) and precharge plus precharge period (6 + 3 = 9).
- R8: Every cycle other than the three commands of a transaction carries NOP, and each transaction issues exactly one activate, one write and one precharge, in that order.
- R9: Request fields are captured at acceptance. Changes to the request inputs, and valid held high while busy, have no effect on a transaction in progress.
- R10: A row never stays open longer than the maximum row-active time (120,000 ns, expressed in cycles).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer can accept a request |
| req_bank | input | 2 | Target bank |
| req_row | input | 12 | Row address |
| req_col | input | 9 | Column address |
| req_data | input | 16 | Write data word |
| req_mask | input | 2 | Byte masks, high = byte not written |
| req_all_banks | input | 1 | Closing precharge applies to all banks |
| done | output | 1 | One-cycle pulse with the precharge command |
| sd_cke | output | 1 | SDRAM clock enable, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Multiplexed address bus |
| sd_dq_o | output | 16 | Data out |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dqm | output | 2 | Byte mask pins |

## Verification
The assertions check the following on every cycle:
- the spacing of each command from the last activate: the write slot, the precharge slot, and the minimum gap to the next activate;
- that done coincides with the precharge;
- that the data output is enabled only with the write;
- that ready drops after an acceptance;
- that the row-open time stays under its maximum.

The values on the pins can only be shown by the bench's scenarios. These are the row, the column with address bit 10 low, the precharge mode bit, the data and the masks, and they depend on what was requested. The same holds for capture of the request at acceptance while the inputs keep changing, and for the exact back-to-back gap of 10 cycles.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    // address bit that carries the precharge mode / auto-precharge flag
    localparam int unsigned AP_BIT = 10;

    function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned tck);
        return (ns + tck - 1) / tck;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Slot of the precharge, counted in cycles from the activate
    function automatic int unsigned pre_slot(input int unsigned rcd, input int unsigned wr,
                                             input int unsigned ras);
        return max2(ras, rcd + wr);
    endfunction

    // Earliest slot of the next activate
    function automatic int unsigned next_slot(input int unsigned pre, input int unsigned rp,
                                              input int unsigned rc);
        return max2(pre + rp, rc);
    endfunction

endpackage

// File: rtl/sdram_wr_ctrl.sv
module sdram_wr_ctrl
    import sdram_wr_pkg::*;
#(
    parameter int unsigned WR_SLOT  = 3,
    parameter int unsigned PRE_SLOT = 6,
    parameter int unsigned NXT_SLOT = 10
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    req_valid,
    output logic    req_ready,
    output logic    accept,
    output sd_cmd_e nxt_cmd
);
    localparam int unsigned CNT_W = $clog2(NXT_SLOT + 1);

    logic             busy;
    logic [CNT_W-1:0] slot;
    logic [CNT_W-1:0] slot_n;

    assign req_ready = !busy;
    assign accept    = req_valid && !busy;
    assign slot_n    = slot + CNT_W'(1);

    always_comb begin
        nxt_cmd = CMD_NOP;
        if (accept) begin
            nxt_cmd = CMD_ACT;
        end else if (busy) begin
            if (slot_n == CNT_W'(WR_SLOT))
                nxt_cmd = CMD_WR;
            else if (slot_n == CNT_W'(PRE_SLOT))
                nxt_cmd = CMD_PRE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            slot <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            slot <= '0;
        end else if (busy) begin
            slot <= slot_n;
            if (slot_n == CNT_W'(NXT_SLOT - 1))
                busy <= 1'b0;
        end
    end

endmodule

// File: rtl/sdram_wr_pins.sv
module sdram_wr_pins
    import sdram_wr_pkg::*;
#(
    parameter int unsigned BANK_W = 2,
    parameter int unsigned ROW_W  = 12,
    parameter int unsigned COL_W  = 9,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned MASK_W = 2,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  sd_cmd_e           nxt_cmd,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_data,
    input  logic [MASK_W-1:0] req_mask,
    input  logic              req_all_banks,
    output sd_cmd_e           cmd_q,
    output logic [BANK_W-1:0] ba_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] dq_q,
    output logic              oe_q,
    output logic [MASK_W-1:0] dqm_q,
    output logic              done_q
);
    // held copy of the request, captured at acceptance
    logic [BANK_W-1:0] bank_h;
    logic [COL_W-1:0]  col_h;
    logic [DATA_W-1:0] data_h;
    logic [MASK_W-1:0] mask_h;
    logic              all_h;

    logic [ADDR_W-1:0] addr_n;
    logic [BANK_W-1:0] ba_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_h <= '0;
            col_h  <= '0;
            data_h <= '0;
            mask_h <= '0;
            all_h  <= 1'b0;
        end else if (accept) begin
            bank_h <= req_bank;
            col_h  <= req_col;
            data_h <= req_data;
            mask_h <= req_mask;
            all_h  <= req_all_banks;
        end
    end

    always_comb begin
        addr_n = '0;
        ba_n   = '0;
        unique case (nxt_cmd)
            CMD_ACT: begin
                addr_n = ADDR_W'(req_row);
                ba_n   = req_bank;
            end
            CMD_WR: begin
                addr_n = ADDR_W'(col_h);   // bit AP_BIT stays low
                ba_n   = bank_h;
            end
            CMD_PRE: begin
                addr_n[AP_BIT] = all_h;
                ba_n           = bank_h;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= CMD_NOP;
            ba_q   <= '0;
            addr_q <= '0;
            dq_q   <= '0;
            oe_q   <= 1'b0;
            dqm_q  <= '1;
            done_q <= 1'b0;
        end else begin
            cmd_q  <= nxt_cmd;
            ba_q   <= ba_n;
            addr_q <= addr_n;
            dq_q   <= (nxt_cmd == CMD_WR) ? data_h : '0;
            oe_q   <= (nxt_cmd == CMD_WR);
            dqm_q  <= (nxt_cmd == CMD_WR) ? mask_h : '1;
            done_q <= (nxt_cmd == CMD_PRE);
        end
    end

endmodule

// File: rtl/sdram_wr_seq.sv
module sdram_wr_seq
    import sdram_wr_pkg::*;
#(
    parameter int unsigned T_CK_NS      = 8,
    parameter int unsigned T_RCD_NS     = 20,
    parameter int unsigned T_RP_NS      = 20,
    parameter int unsigned T_RAS_NS     = 48,
    parameter int unsigned T_RC_NS      = 80,
    parameter int unsigned T_WR_NS      = 15,
    parameter int unsigned T_RAS_MAX_NS = 120000,
    parameter int unsigned BANK_W       = 2,
    parameter int unsigned ROW_W        = 12,
    parameter int unsigned COL_W        = 9,
    parameter int unsigned DATA_W       = 16,
    parameter int unsigned MASK_W       = 2,
    parameter int unsigned ADDR_W       = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_data,
    input  logic [MASK_W-1:0] req_mask,
    input  logic              req_all_banks,
    output logic              done,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [DATA_W-1:0] sd_dq_o,
    output logic              sd_dq_oe,
    output logic [MASK_W-1:0] sd_dqm
);
    localparam int unsigned RCD_C    = ns2cyc(T_RCD_NS, T_CK_NS);
    localparam int unsigned RP_C     = ns2cyc(T_RP_NS, T_CK_NS);
    localparam int unsigned RAS_C    = ns2cyc(T_RAS_NS, T_CK_NS);
    localparam int unsigned RC_C     = ns2cyc(T_RC_NS, T_CK_NS);
    localparam int unsigned WR_C     = ns2cyc(T_WR_NS, T_CK_NS);
    localparam int unsigned PRE_SLOT = pre_slot(RCD_C, WR_C, RAS_C);
    localparam int unsigned NXT_SLOT = next_slot(PRE_SLOT, RP_C, RC_C);

    logic    accept;
    sd_cmd_e nxt_cmd;
    sd_cmd_e cmd_q;

    sdram_wr_ctrl #(
        .WR_SLOT (RCD_C),
        .PRE_SLOT(PRE_SLOT),
        .NXT_SLOT(NXT_SLOT)
    ) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_ready(req_ready),
        .accept   (accept),
        .nxt_cmd  (nxt_cmd)
    );

    sdram_wr_pins #(
        .BANK_W(BANK_W),
        .ROW_W (ROW_W),
        .COL_W (COL_W),
        .DATA_W(DATA_W),
        .MASK_W(MASK_W),
        .ADDR_W(ADDR_W)
    ) pins_i (
        .clk          (clk),
        .rst          (rst),
        .accept       (accept),
        .nxt_cmd      (nxt_cmd),
        .req_bank     (req_bank),
        .req_row      (req_row),
        .req_col      (req_col),
        .req_data     (req_data),
        .req_mask     (req_mask),
        .req_all_banks(req_all_banks),
        .cmd_q        (cmd_q),
        .ba_q         (sd_ba),
        .addr_q       (sd_addr),
        .dq_q         (sd_dq_o),
        .oe_q         (sd_dq_oe),
        .dqm_q        (sd_dqm),
        .done_q       (done)
    );

    assign sd_cke = 1'b1;
    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

endmodule

// File: rtl/sdram_wr_chk.sv
module sdram_wr_chk
    import sdram_wr_pkg::*;
#(
    parameter int unsigned T_CK_NS      = 8,
    parameter int unsigned T_RCD_NS     = 20,
    parameter int unsigned T_RP_NS      = 20,
    parameter int unsigned T_RAS_NS     = 48,
    parameter int unsigned T_RC_NS      = 80,
    parameter int unsigned T_WR_NS      = 15,
    parameter int unsigned T_RAS_MAX_NS = 120000
) (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic done,
    input logic sd_cs_n,
    input logic sd_ras_n,
    input logic sd_cas_n,
    input logic sd_we_n,
    input logic sd_dq_oe
);
    localparam int unsigned RCD_C   = ns2cyc(T_RCD_NS, T_CK_NS);
    localparam int unsigned WR_C    = ns2cyc(T_WR_NS, T_CK_NS);
    localparam int unsigned RAS_C   = ns2cyc(T_RAS_NS, T_CK_NS);
    localparam int unsigned PRE_C   = pre_slot(RCD_C, WR_C, RAS_C);
    localparam int unsigned NXT_C   = next_slot(PRE_C, ns2cyc(T_RP_NS, T_CK_NS),
                                                ns2cyc(T_RC_NS, T_CK_NS));
    localparam int unsigned MAXO_C  = T_RAS_MAX_NS / T_CK_NS;
    localparam int unsigned SW      = $clog2(NXT_C + 1);
    localparam int unsigned OW      = $clog2(MAXO_C + 2);

    logic [3:0]    cmd_w;
    logic [SW-1:0] since;
    logic          seen_act;
    logic          open_q;
    logic [OW-1:0] open_cnt;

    assign cmd_w = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    always_ff @(posedge clk) begin
        if (rst) begin
            since    <= '0;
            seen_act <= 1'b0;
            open_q   <= 1'b0;
            open_cnt <= '0;
        end else begin
            if (cmd_w == CMD_ACT) begin
                since    <= SW'(1);
                seen_act <= 1'b1;
            end else if (since != SW'(NXT_C)) begin
                since <= since + SW'(1);
            end
            if (cmd_w == CMD_ACT) begin
                open_q   <= 1'b1;
                open_cnt <= OW'(1);
            end else if (cmd_w == CMD_PRE) begin
                open_q   <= 1'b0;
                open_cnt <= '0;
            end else if (open_q) begin
                open_cnt <= open_cnt + OW'(1);
            end
        end
    end

    // R2
    act_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (cmd_w == CMD_ACT));

    // R3
    wr_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_w == CMD_WR) |-> (seen_act && since == SW'(RCD_C)));

    // R4
    oe_only_write_chk: assert property (@(posedge clk) disable iff (rst)
        sd_dq_oe |-> (cmd_w == CMD_WR));

    // R5
    pre_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_w == CMD_PRE) |-> (seen_act && since == SW'(PRE_C)));

    // R6
    done_with_pre_chk: assert property (@(posedge clk) disable iff (rst)
        done == (cmd_w == CMD_PRE));

    // R7
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R7
    act_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_w == CMD_ACT && seen_act) |-> (since >= SW'(NXT_C)));

    // R10
    row_open_max_chk: assert property (@(posedge clk) disable iff (rst)
        open_cnt <= OW'(MAXO_C));

endmodule

bind sdram_wr_seq sdram_wr_chk #(
    .T_CK_NS     (T_CK_NS),
    .T_RCD_NS    (T_RCD_NS),
    .T_RP_NS     (T_RP_NS),
    .T_RAS_NS    (T_RAS_NS),
    .T_RC_NS     (T_RC_NS),
    .T_WR_NS     (T_WR_NS),
    .T_RAS_MAX_NS(T_RAS_MAX_NS)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .done     (done),
    .sd_cs_n  (sd_cs_n),
    .sd_ras_n (sd_ras_n),
    .sd_cas_n (sd_cas_n),
    .sd_we_n  (sd_we_n),
    .sd_dq_oe (sd_dq_oe)
);

// File: tb/sdram_wr_seq_tb_top.sv
module sdram_wr_seq_tb_top;

    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_NOP = 4'b0111;
    localparam int WR_OFF  = 3;
    localparam int PRE_OFF = 6;
    localparam int GAP     = 10;

    typedef struct {
        logic [3:0]  cmd;
        logic [1:0]  ba;
        logic [11:0] addr;
        logic [15:0] dq;
        logic [1:0]  dqm;
        bit          b2b;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_bank = '0;
    logic [11:0] req_row = '0;
    logic [8:0]  req_col = '0;
    logic [15:0] req_data = '0;
    logic [1:0]  req_mask = '0;
    logic        req_all_banks = 1'b0;
    logic        done, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [1:0]  sd_ba, sd_dqm;
    logic [11:0] sd_addr;
    logic [15:0] sd_dq_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    item_t exp_q[$];

    always #10 clk = ~clk;

    sdram_wr_seq dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_data(req_data), .req_mask(req_mask), .req_all_banks(req_all_banks),
        .done(done), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
        .sd_dq_o(sd_dq_o), .sd_dq_oe(sd_dq_oe), .sd_dqm(sd_dqm)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Driver: queue the expected commands, then present the request
    task automatic send(input logic [1:0] bank, input logic [11:0] row, input logic [8:0] col,
                        input logic [15:0] data, input logic [1:0] mask, input logic all_b,
                        input bit b2b);
        item_t it;
        it = '{cmd: C_ACT, ba: bank, addr: row, dq: 16'h0, dqm: 2'b11, b2b: b2b};
        exp_q.push_back(it);
        it = '{cmd: C_WR, ba: bank, addr: {3'b000, col}, dq: data, dqm: mask, b2b: 1'b0};
        exp_q.push_back(it);
        it = '{cmd: C_PRE, ba: bank, addr: (all_b ? 12'h400 : 12'h000), dq: 16'h0,
               dqm: 2'b11, b2b: 1'b0};
        exp_q.push_back(it);
        @(negedge clk);
        req_bank = bank; req_row = row; req_col = col;
        req_data = data; req_mask = mask; req_all_banks = all_b;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    // Monitor / scoreboard
    int  cyc = 0;
    int  last_act = 0;
    bit  have_act = 0;

    always @(negedge clk) begin
        if (!rst && !finished) begin
            logic [3:0] cmd;
            item_t e;
            cyc++;
            cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (have_act && (cyc - last_act) == 0 + 1)
                chk(req_ready == 1'b0, "R7", "ready low after activate", req_ready, 0);
            if (have_act && (cyc - last_act) == GAP - 1)
                chk(req_ready == 1'b1, "R7", "ready back at gap-1", req_ready, 1);
            if (cmd == C_NOP) begin
                chk(!sd_dq_oe && !done && sd_dqm == 2'b11 && sd_dq_o == 16'h0, "R4",
                    "idle cycle oe/done/dqm/dq", {13'h0, sd_dq_oe, done, sd_dqm, sd_dq_o},
                    {15'h0, 1'b0, 2'b11, 16'h0});
            end else if (exp_q.size() == 0) begin
                chk(1'b0, "R8", "unexpected command", cmd, C_NOP);
            end else begin
                e = exp_q.pop_front();
                chk(cmd == e.cmd, "R8", "command order", cmd, e.cmd);
                chk(sd_ba == e.ba, "R9", "bank pins", sd_ba, e.ba);
                chk(sd_addr == e.addr, (cmd == C_ACT) ? "R2" : (cmd == C_WR) ? "R3" : "R5",
                    "address bus", sd_addr, e.addr);
                chk(sd_dq_o == e.dq && sd_dqm == e.dqm && sd_dq_oe == (cmd == C_WR), "R4",
                    "data/mask/oe", {sd_dq_oe, sd_dqm, sd_dq_o}, {(cmd == C_WR), e.dqm, e.dq});
                chk(done == (cmd == C_PRE), "R6", "done pulse", done, (cmd == C_PRE));
                if (cmd == C_ACT) begin
                    if (have_act && e.b2b)
                        chk((cyc - last_act) == GAP, "R7", "back-to-back activate gap",
                            cyc - last_act, GAP);
                    else if (have_act)
                        chk((cyc - last_act) >= GAP, "R7", "activate gap minimum",
                            cyc - last_act, GAP);
                    last_act = cyc;
                    have_act = 1;
                end else if (cmd == C_WR) begin
                    chk((cyc - last_act) == WR_OFF, "R3", "write slot", cyc - last_act, WR_OFF);
                end else begin
                    chk((cyc - last_act) == PRE_OFF, "R5", "precharge slot",
                        cyc - last_act, PRE_OFF);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "R8", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP && sd_cke && !sd_dq_oe &&
            req_ready && !done && sd_dqm == 2'b11, "R1", "state in reset",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke, sd_dq_oe, req_ready, done, sd_dqm},
            {C_NOP, 1'b1, 1'b0, 1'b1, 1'b0, 2'b11});
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP && sd_cke && req_ready,
            "R1", "first cycle after reset",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke, req_ready}, {C_NOP, 2'b11});

        // single writes, single-bank and all-banks precharge, varied masks
        send(2'd1, 12'hABC, 9'h1FF, 16'hA5A5, 2'b00, 1'b0, 0);
        repeat (15) @(negedge clk);
        send(2'd2, 12'h003, 9'h000, 16'h0FF0, 2'b01, 1'b1, 0);
        repeat (12) @(negedge clk);
        // R9: back-to-back; second request's fields change during first's busy window
        send(2'd3, 12'hFFF, 9'h155, 16'h1234, 2'b10, 1'b1, 0);
        send(2'd0, 12'h800, 9'h0AA, 16'hFFFF, 2'b11, 1'b0, 1);
        send(2'd1, 12'h555, 9'h100, 16'h8001, 2'b00, 1'b0, 1);
        repeat (30) @(negedge clk);
        chk(exp_q.size() == 0, "R8", "all expected commands seen", exp_q.size(), 0);
        chk(req_ready == 1'b1, "R7", "ready when idle", req_ready, 1);
        finish_run();
    end

endmodule